// File: doc/BRIEF.md
# Module clock enable sequencer

This block switches a peripheral module's functional clock on or off by rewriting the two-bit mode field of a 32-bit clock-control register. It then reads that register repeatedly until the module's two-bit idle-status field shows the expected state, or until a microsecond timeout runs out. Before it touches the register on an enable, it asks the parent clock-domain controller for permission. On a disable, it lets the parent domain go only after the register has been written and polled.

A request carries an operation (enable, disable or status query), the configured mode value and a skip-polling flag. Only one request is handled at a time. When the sequence finishes, the block gives a one-cycle done pulse. An error code and the query result stay valid until the next request is accepted. The register is reached through a single-register valid/ready master port. The parent domain is reached through a valid/ready handshake that carries an acquire/release flag and a grant answer. Timeouts count pulses of an external 1 µs tick.

Top module: `mod_clk_seq`

## Requirements
- R1: An enable writes the configured mode value (1 = hardware-controlled, 2 = software-controlled) into register bits 1:0. It uses a read-modify-write: one read, then one write whose bits 31:2 equal the value that was read.
- R2: A disable performs the same read-modify-write but writes 0 into bits 1:0, keeping bits 31:2 as read.
- R3: After the write of an enable, the block reads the register until bits 17:16 read 0 (functional) or 2 (interface idle). It then finishes with errCode 0. Codes 1 and 3 cause another read.
- R4: If an enable poll has not succeeded after ENA_TIMEOUT_US tick pulses, the enable ends with errCode 1 (busy error) and no domain release.
- R5: After the write of a disable, the block reads the register until bits 17:16 read 3 (disabled), with errCode 0.
- R6: If a disable poll has not succeeded after DIS_TIMEOUT_US tick pulses, errCode becomes 2, but the domain release still takes place before done.
- R7: An enable acquires the parent domain (domOp = 1) before any register access. If domGrant is low at domReady, the enable ends with errCode 3 and makes no register access.
- R8: A disable releases the parent domain (domOp = 0) after its last register transfer. This happens whether polling succeeded, timed out or was skipped. A disable never acquires the domain.
- R9: With reqNoPoll set, the sequence makes no status read after the write. An enable finishes right after the write; a disable goes straight to the release.
- R10: A request whose mode value is 0 finishes with done and errCode 0, with no register or domain transfer.
- R11: A query (reqOp 2 or 3) reads the register once and writes nothing. isEnabled is set when any bit of the mode value is also set in register bits 1:0. With mode 0, isEnabled is 0.
- R12: reqOp encodes 0 = enable, 1 = disable. Requests that arrive while busy is high are ignored. done is high for exactly one cycle per accepted request. errCode and isEnabled hold their values until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqOp | input | 2 | 0 enable, 1 disable, 2/3 query |
| reqMode | input | 2 | Configured mode value |
| reqNoPoll | input | 1 | Skip status polling |
| tickUs | input | 1 | One-cycle pulse every microsecond |
| busValid | output | 1 | Register transfer request |
| busWrite | output | 1 | 1 write, 0 read |
| busWdata | output | 32 | Write data |
| busReady | input | 1 | Transfer completes in this cycle |
| busRdata | input | 32 | Read data, valid with busReady |
| domValid | output | 1 | Parent domain handshake request |
| domOp | output | 1 | 1 acquire, 0 release |
| domReady | input | 1 | Parent domain answer strobe |
| domGrant | input | 1 | Acquire accepted (sampled with domReady) |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |
| errCode | output | 2 | 0 ok, 1 enable timeout, 2 disable timeout, 3 domain refused |
| isEnabled | output | 1 | Query result |

## Verification
A wrong sequencer state shows up at the ports as a transfer out of order. Examples are a register access before the domain grant, a release before the write, or a status read after a skip-polling write. Each of these is visible on the cycle it happens. A bad timer or status decode shows up as a wrong poll count, or as done arriving outside the window of limit × tick period, within one timeout. A corrupted merge shows up on busWdata in the write cycle as a change in bits 31:2.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int REG_W = 32;

  localparam logic [1:0] OP_ENA = 2'd0;
  localparam logic [1:0] OP_DIS = 2'd1;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_BUSY = 2'd1;
  localparam logic [1:0] ERR_DTMO = 2'd2;
  localparam logic [1:0] ERR_DOM  = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_DOMACQ, S_READ, S_WRITE, S_POLL, S_DOMREL, S_DONE
  } seqState_t;

  typedef struct packed {
    logic latchReq;
    logic captureRd;
    logic clrTimer;
  } dpStrobe_t;
endpackage

// File: rtl/mcs_datapath.sv
module mcs_datapath
  import mcs_pkg::*;
#(
  parameter int ENA_TIMEOUT_US = 2000,
  parameter int DIS_TIMEOUT_US = 5000
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [1:0]       reqOp,
  input  logic [1:0]       reqMode,
  input  logic             reqNoPoll,
  input  logic             tickUs,
  input  logic [REG_W-1:0] busRdata,
  output logic [1:0]       opQ,
  output logic             noPollQ,
  output logic [REG_W-1:0] busWdata,
  output logic             enaReady,
  output logic             disIdle,
  output logic             timerHit,
  output logic             isEnabled
);
  localparam int MAX_TO = (ENA_TIMEOUT_US > DIS_TIMEOUT_US) ? ENA_TIMEOUT_US : DIS_TIMEOUT_US;
  localparam int TW = $clog2(MAX_TO + 1);
  localparam logic [TW-1:0] ENA_LIM = TW'(ENA_TIMEOUT_US);
  localparam logic [TW-1:0] DIS_LIM = TW'(DIS_TIMEOUT_US);
  localparam logic [TW-1:0] MAX_LIM = TW'(MAX_TO);

  logic [1:0]       modeQ;
  logic [REG_W-1:2] keepQ;
  logic [TW-1:0]    timer;
  logic [TW-1:0]    limit;
  logic [1:0]       stField;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ     <= OP_ENA;
      modeQ   <= 2'd0;
      noPollQ <= 1'b0;
    end else if (strobe.latchReq) begin
      opQ     <= reqOp;
      modeQ   <= reqMode;
      noPollQ <= reqNoPoll;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) keepQ <= '0;
    else if (strobe.captureRd) keepQ <= busRdata[REG_W-1:2];
  end

  assign busWdata = {keepQ, (opQ == OP_ENA) ? modeQ : 2'b00};

  assign stField  = busRdata[17:16];
  assign enaReady = (stField == 2'd0) || (stField == 2'd2);
  assign disIdle  = (stField == 2'd3);

  assign limit    = (opQ == OP_ENA) ? ENA_LIM : DIS_LIM;
  assign timerHit = (timer >= limit);

  always_ff @(posedge clk) begin
    if (!rstN) timer <= '0;
    else if (strobe.clrTimer) timer <= '0;
    else if (tickUs && !timerHit) timer <= timer + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) isEnabled <= 1'b0;
    else if (strobe.latchReq) isEnabled <= 1'b0;
    else if (strobe.captureRd && opQ[1]) isEnabled <= |(busRdata[1:0] & modeQ);
  end

  // R4: the timeout counter saturates and never passes the larger limit
  a_r4_timer_sat: assert property (@(posedge clk) disable iff (!rstN)
    timer <= MAX_LIM);

  // R12: the latched request holds steady while a sequence is running
  a_r12_hold_req: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchReq |=> $stable(opQ) && $stable(noPollQ));
endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
  import mcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic [1:0] reqMode,
  input  logic [1:0] opQ,
  input  logic       noPollQ,
  input  logic       enaReady,
  input  logic       disIdle,
  input  logic       timerHit,
  input  logic       busReady,
  input  logic       domReady,
  input  logic       domGrant,
  output dpStrobe_t  strobe,
  output logic       busValid,
  output logic       busWrite,
  output logic       domValid,
  output logic       domOp,
  output logic       done,
  output logic       busy,
  output logic [1:0] errCode
);
  seqState_t  state, nextState;
  logic       errSet;
  logic [1:0] errVal;
  logic       isEna;
  logic       grantSeen;
  logic       wroteSeen;

  assign isEna = (opQ == OP_ENA);

  always_comb begin
    nextState = state;
    strobe    = '0;
    errSet    = 1'b0;
    errVal    = ERR_NONE;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          if (reqMode == 2'd0)      nextState = S_DONE;
          else if (reqOp == OP_ENA) nextState = S_DOMACQ;
          else                      nextState = S_READ;
        end
      end
      S_DOMACQ: begin
        if (domReady) begin
          if (domGrant) nextState = S_READ;
          else begin
            errSet    = 1'b1;
            errVal    = ERR_DOM;
            nextState = S_DONE;
          end
        end
      end
      S_READ: begin
        if (busReady) begin
          strobe.captureRd = 1'b1;
          nextState = opQ[1] ? S_DONE : S_WRITE;
        end
      end
      S_WRITE: begin
        if (busReady) begin
          if (noPollQ) nextState = isEna ? S_DONE : S_DOMREL;
          else begin
            strobe.clrTimer = 1'b1;
            nextState = S_POLL;
          end
        end
      end
      S_POLL: begin
        if (isEna) begin
          if (busReady && enaReady) nextState = S_DONE;
          else if (timerHit) begin
            errSet    = 1'b1;
            errVal    = ERR_BUSY;
            nextState = S_DONE;
          end
        end else begin
          if (busReady && disIdle) nextState = S_DOMREL;
          else if (timerHit) begin
            errSet    = 1'b1;
            errVal    = ERR_DTMO;
            nextState = S_DOMREL;
          end
        end
      end
      S_DOMREL: if (domReady) nextState = S_DONE;
      S_DONE:   nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      errCode   <= ERR_NONE;
      grantSeen <= 1'b0;
      wroteSeen <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.latchReq) begin
        errCode   <= ERR_NONE;
        grantSeen <= 1'b0;
        wroteSeen <= 1'b0;
      end else begin
        if (errSet) errCode <= errVal;
        if (state == S_DOMACQ && domReady && domGrant) grantSeen <= 1'b1;
        if (state == S_WRITE && busReady) wroteSeen <= 1'b1;
      end
    end
  end

  assign busValid = (state == S_READ) || (state == S_WRITE) || (state == S_POLL);
  assign busWrite = (state == S_WRITE);
  assign domValid = (state == S_DOMACQ) || (state == S_DOMREL);
  assign domOp    = (state == S_DOMACQ);
  assign done     = (state == S_DONE);
  assign busy     = (state != S_IDLE);

  // R7: no register access on an enable before the domain granted it
  a_r7_grant_first: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && isEna) |-> grantSeen);

  // R8: the domain is released only after the register write completed
  a_r8_release_last: assert property (@(posedge clk) disable iff (!rstN)
    (domValid && !domOp) |-> wroteSeen);

  // R12: done is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: a zero mode value goes straight to completion
  a_r10_zero_mode: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && reqMode == 2'd0) |=> done && !busValid && !domValid);

  // R1: a pending transfer keeps its direction until it completes
  a_r1_bus_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady && !timerHit) |=> busValid && $stable(busWrite));
endmodule

// File: rtl/mod_clk_seq.sv
module mod_clk_seq
  import mcs_pkg::*;
#(
  parameter int ENA_TIMEOUT_US = 2000,
  parameter int DIS_TIMEOUT_US = 5000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic [1:0]  reqMode,
  input  logic        reqNoPoll,
  input  logic        tickUs,
  output logic        busValid,
  output logic        busWrite,
  output logic [31:0] busWdata,
  input  logic        busReady,
  input  logic [31:0] busRdata,
  output logic        domValid,
  output logic        domOp,
  input  logic        domReady,
  input  logic        domGrant,
  output logic        done,
  output logic        busy,
  output logic [1:0]  errCode,
  output logic        isEnabled
);
  dpStrobe_t  strobe;
  logic [1:0] opQ;
  logic       noPollQ;
  logic       enaReady;
  logic       disIdle;
  logic       timerHit;

  mcs_datapath #(
    .ENA_TIMEOUT_US(ENA_TIMEOUT_US),
    .DIS_TIMEOUT_US(DIS_TIMEOUT_US)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqOp(reqOp), .reqMode(reqMode), .reqNoPoll(reqNoPoll),
    .tickUs(tickUs), .busRdata(busRdata),
    .opQ(opQ), .noPollQ(noPollQ), .busWdata(busWdata),
    .enaReady(enaReady), .disIdle(disIdle), .timerHit(timerHit),
    .isEnabled(isEnabled)
  );

  mcs_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqMode(reqMode), .opQ(opQ), .noPollQ(noPollQ),
    .enaReady(enaReady), .disIdle(disIdle), .timerHit(timerHit),
    .busReady(busReady), .domReady(domReady), .domGrant(domGrant),
    .strobe(strobe), .busValid(busValid), .busWrite(busWrite),
    .domValid(domValid), .domOp(domOp), .done(done), .busy(busy),
    .errCode(errCode)
  );
endmodule

// File: tb/test_mod_clk_seq.sv
module test_mod_clk_seq;
  localparam int ENA_TO = 20;
  localparam int DIS_TO = 40;
  localparam int TP = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic [1:0] reqMode = 2'd0;
  logic reqNoPoll = 1'b0;
  logic tickUs = 1'b0;
  logic busValid, busWrite, busReady = 1'b0;
  logic [31:0] busWdata, busRdata;
  logic domValid, domOp, domReady = 1'b0, domGrant = 1'b1;
  logic done, busy, isEnabled;
  logic [1:0] errCode;

  mod_clk_seq #(.ENA_TIMEOUT_US(ENA_TO), .DIS_TIMEOUT_US(DIS_TO)) i_mod_clk_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqMode(reqMode),
    .reqNoPoll(reqNoPoll), .tickUs(tickUs), .busValid(busValid), .busWrite(busWrite),
    .busWdata(busWdata), .busReady(busReady), .busRdata(busRdata),
    .domValid(domValid), .domOp(domOp), .domReady(domReady), .domGrant(domGrant),
    .done(done), .busy(busy), .errCode(errCode), .isEnabled(isEnabled)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] regVal = 32'h0;
  logic [31:0] firstRead, lastW;
  logic [1:0] stInit = 2'd1, stFinal = 2'd0, curSt;
  int stDelay = 0, busLat = 0, latCnt = 0, tickCnt = 0;
  int reads, writes, pollReads, acq, rel, doneCnt;
  int acqCyc, relCyc, firstBusCyc, lastBusCyc;
  bit wroteFlag;

  assign curSt = !wroteFlag ? stInit : ((pollReads >= stDelay) ? stFinal : stInit);
  assign busRdata = (regVal & ~32'h0003_0000) | ({30'd0, curSt} << 16);

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R12 watchdog: actual %0d cycles, expected below 150000", cyc);
      summary();
      $finish;
    end
    doneCnt += done ? 1 : 0;
    if (busValid && busReady) begin
      if (reads + writes == 0) firstBusCyc = cyc;
      lastBusCyc = cyc;
      latCnt = 0;
      if (busWrite) begin
        writes++; lastW = busWdata; regVal = busWdata; wroteFlag = 1'b1; pollReads = 0;
      end else begin
        if (!wroteFlag) firstRead = busRdata;
        else pollReads++;
        reads++;
      end
    end
    if (domValid && domReady) begin
      if (domOp) begin acq++; acqCyc = cyc; end
      else begin rel++; relCyc = cyc; end
    end
  end

  always @(negedge clk) begin
    tickCnt++;
    tickUs = (tickCnt % TP == 0);
    if (busValid) begin
      if (latCnt >= busLat) busReady = 1'b1;
      else begin busReady = 1'b0; latCnt++; end
    end else begin
      busReady = 1'b0; latCnt = 0;
    end
    domReady = domValid;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearStats(logic [31:0] init);
    regVal = init; reads = 0; writes = 0; pollReads = 0; acq = 0; rel = 0;
    doneCnt = 0; wroteFlag = 1'b0; acqCyc = 0; relCyc = 0; firstBusCyc = 0;
    lastBusCyc = 0; firstRead = 0; lastW = 0;
  endtask

  task automatic issue(logic [1:0] op, logic [1:0] mode, logic np);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqMode = mode; reqNoPoll = np;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(output int n);
    n = 1;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 2000) check(0, "R12", "done never seen", n, 0);
    @(negedge clk);
  endtask

  initial begin
    int n;
    int idx = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && errCode == 0 && !busValid && !domValid, "R12", "reset idle",
          {busy, done, busValid, domValid}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Enable success sweep (R1, R3, R7)
    for (int m = 1; m < 4; m++)
      for (int f = 0; f < 2; f++)
        for (int d = 0; d < 4; d += 3 - d / 2) begin
          idx++;
          clearStats(32'hC3A5_5A3C ^ (idx * 32'h0101_0107));
          stInit = 2'd1 + 2'(2 * (idx % 2)); stFinal = f ? 2'd2 : 2'd0; stDelay = d;
          busLat = idx % 3; domGrant = 1'b1;
          issue(2'd0, 2'(m), 1'b0);
          waitDone(n);
          check(errCode == 0, "R3", "enable error code", errCode, 0);
          check(pollReads == d + 1, "R3", "enable poll reads", pollReads, d + 1);
          check(writes == 1 && lastW[1:0] == 2'(m), "R1", "enable mode field", lastW[1:0], m);
          check(lastW[31:2] == firstRead[31:2], "R1", "enable upper bits kept",
                lastW[31:2], firstRead[31:2]);
          check(acq == 1 && rel == 0 && acqCyc < firstBusCyc, "R7", "acquire before bus",
                acqCyc, firstBusCyc - 1);
          check(doneCnt == 1, "R12", "single done pulse", doneCnt, 1);
        end

    // Disable success sweep (R2, R5, R8)
    for (int m = 1; m < 4; m++)
      for (int d = 0; d < 3; d += 2) begin
        idx++;
        clearStats(32'h3C5A_A5C3 ^ (idx * 32'h0011_0005));
        stInit = 2'(d % 3); stFinal = 2'd3; stDelay = d; busLat = idx % 2;
        issue(2'd1, 2'(m), 1'b0);
        waitDone(n);
        check(errCode == 0, "R5", "disable error code", errCode, 0);
        check(pollReads == d + 1, "R5", "disable poll reads", pollReads, d + 1);
        check(lastW[1:0] == 2'd0 && lastW[31:2] == firstRead[31:2], "R2", "disable write value",
              lastW, {firstRead[31:2], 2'b00});
        check(acq == 0 && rel == 1 && relCyc > lastBusCyc, "R8", "release after bus",
              relCyc, lastBusCyc + 1);
      end

    // Enable timeout with status stuck at 1 or 3 (R4)
    for (int s = 1; s < 4; s += 2) begin
      clearStats(32'h0F0F_F0F0);
      stInit = 2'(s); stFinal = 2'(s); stDelay = 0; busLat = s - 1;
      issue(2'd0, 2'd2, 1'b0);
      waitDone(n);
      check(errCode == 1, "R4", "enable timeout code", errCode, 1);
      check(n >= ENA_TO * TP - TP && n <= ENA_TO * TP + 30, "R4", "enable timeout cycles",
            n, ENA_TO * TP);
      check(rel == 0, "R4", "no release after enable timeout", rel, 0);
    end

    // Disable timeout with status stuck at 0 or 2 (R6)
    for (int s = 0; s < 3; s += 2) begin
      clearStats(32'hFFFF_FFFF);
      stInit = 2'(s); stFinal = 2'(s); stDelay = 0; busLat = 1;
      issue(2'd1, 2'd1, 1'b0);
      waitDone(n);
      check(errCode == 2, "R6", "disable timeout code", errCode, 2);
      check(n >= DIS_TO * TP - TP && n <= DIS_TO * TP + 30, "R6", "disable timeout cycles",
            n, DIS_TO * TP);
      check(rel == 1 && relCyc > lastBusCyc, "R6", "release after timeout", rel, 1);
    end

    // Domain refusal (R7)
    clearStats(32'h1234_5678);
    domGrant = 1'b0;
    issue(2'd0, 2'd1, 1'b0);
    waitDone(n);
    check(errCode == 3, "R7", "refused code", errCode, 3);
    check(reads + writes == 0, "R7", "no bus after refusal", reads + writes, 0);
    domGrant = 1'b1;

    // Skip polling (R9, R8)
    clearStats(32'h8765_4321);
    stInit = 2'd1; stFinal = 2'd1; busLat = 0;
    issue(2'd0, 2'd1, 1'b1);
    waitDone(n);
    check(reads == 1 && writes == 1 && errCode == 0, "R9", "enable skip transfers", reads, 1);
    clearStats(32'h8765_4321);
    issue(2'd1, 2'd2, 1'b1);
    waitDone(n);
    check(reads == 1 && writes == 1, "R9", "disable skip transfers", reads, 1);
    check(rel == 1 && relCyc > lastBusCyc, "R8", "release after skipped poll", rel, 1);

    // Zero mode value (R10)
    for (int op = 0; op < 3; op++) begin
      clearStats(32'hFFFF_FFFF);
      issue(2'(op), 2'd0, 1'b0);
      waitDone(n);
      check(reads + writes + acq + rel == 0 && errCode == 0 && !isEnabled && n <= 3, "R10",
            "zero mode no activity", reads + writes + acq + rel, 0);
    end

    // Query sweep (R11)
    for (int lo = 0; lo < 4; lo++)
      for (int m = 1; m < 4; m++) begin
        clearStats({30'h2AAA_5555, 2'(lo)});
        stInit = 2'd3;
        issue(2'd2 + 2'(m % 2), 2'(m), 1'b0);
        waitDone(n);
        check(isEnabled == ((lo & m) != 0), "R11", "query result", isEnabled, (lo & m) != 0);
        check(reads == 1 && writes == 0, "R11", "query transfers", reads * 10 + writes, 10);
      end

    // Requests while busy are ignored; outputs sticky (R12)
    clearStats({30'h0, 2'd3});
    stInit = 2'd1; stFinal = 2'd1; busLat = 0;
    issue(2'd0, 2'd1, 1'b0);
    repeat (8) @(negedge clk);
    issue(2'd2, 2'd1, 1'b0);
    waitDone(n);
    repeat (6) @(negedge clk);
    check(doneCnt == 1, "R12", "one done for ignored request", doneCnt, 1);
    check(errCode == 1 && !isEnabled, "R12", "sticky error and query clear", errCode, 1);
    check(writes == 1, "R12", "busy request caused no extra write", writes, 1);

    summary();
    $finish;
  end
endmodule